// File: doc/BRIEF.md
# Per-Queue Envelope Assembler with Release Timer

This block is placed beside one virtual output queue on an ingress linecard. It counts the cells waiting for one output port and groups them into envelopes of a fixed number of cells. The central scheduler can then decide once per envelope rather than once per cell. A request goes out as soon as a whole envelope is waiting.

A queue with light traffic might never fill an envelope, and its cells would wait forever. To prevent this, a run-time release timer lets a partly filled envelope go after a set number of cycles. The empty slots of such an envelope are padding, and padding is capacity the fabric loses. Setting the limit to zero turns the timer off, so only full envelopes are ever requested. When the scheduler grants a request, the block reports in the next cycle how many real cells the envelope carries and how many slots are padding. Cell storage and the scheduler are outside this block.

Top module: `env_assembler`

## Requirements
- R1: After reset the backlog is zero, `env_req` is low and `rpt_vld` is low.
- R2: `env_req` is high in every cycle in which the backlog is at least ENV_CELLS (4 by default).
- R3: The age counter is zero while the backlog is zero. It rises by one at each clock edge at which the backlog is non-zero, and it saturates. With a non-zero `tmo_limit` of T, `env_req` rises after the T-th clock edge that follows the edge at which the first cell entered an empty queue. It stays high until a grant is taken.
- R4: A `tmo_limit` of zero disables the timer: with fewer than ENV_CELLS cells queued, `env_req` stays low however long the cells wait.
- R5: `grant_in` while `env_req` is low has no effect: no report is produced and the backlog is unchanged.
- R6: A grant taken while `env_req` is high yields, one cycle later, a single-cycle `rpt_vld` with `rpt_cells` = min(backlog, ENV_CELLS), `rpt_pad` = ENV_CELLS − `rpt_cells`, and `rpt_padded` = 1 exactly when `rpt_pad` is non-zero.
- R7: A cell arriving in the same cycle as a taken grant is not placed in the granted envelope. It counts toward the next envelope.
- R8: A taken grant clears the age counter. Cells left in the queue after the grant start aging from that edge.
- R9: A cell arriving while the backlog equals QDEPTH (15 by default) is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_in | input | 1 | One cell joins the queue this cycle |
| grant_in | input | 1 | Scheduler grants the pending envelope |
| tmo_limit | input | TMO_W | Release timer limit in cycles, 0 disables |
| env_req | output | 1 | Envelope ready for scheduling |
| rpt_vld | output | 1 | Report of the envelope just granted |
| rpt_cells | output | $clog2(ENV_CELLS+1) | Real cells in the granted envelope |
| rpt_pad | output | $clog2(ENV_CELLS+1) | Padding slots in the granted envelope |
| rpt_padded | output | 1 | Granted envelope holds padding |

## Verification
The bench sweeps every partial fill level against several timer limits. For each case it checks the exact cycle in which the request rises. A design with an off-by-one timer start would raise the request one cycle early or late. One that ages an empty queue would fire at once on the first cell.

Directed cases cover the following hazards. A disabled timer held long enough to saturate the age counter must not release a partial envelope. A stray grant with no request pending must change nothing. A cell arriving with a grant must not be folded into the granted envelope. Leftover cells must age from the grant edge. The queue is also pushed past its depth, and the counter must saturate there rather than wrap.

// File: rtl/env_asm_pkg.sv
package env_asm_pkg;

  // cells placed in an envelope for a given backlog
  function automatic int take_of(input int backlog, input int env_cells);
    return (backlog < env_cells) ? backlog : env_cells;
  endfunction

  // empty slots of an envelope that carries 'taken' cells
  function automatic int pad_of(input int taken, input int env_cells);
    return env_cells - taken;
  endfunction

endpackage

// File: rtl/env_backlog_ctr.sv
module env_backlog_ctr #(
  parameter int QDEPTH = 15,
  parameter int CW     = 4,
  parameter int PW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cell_in,
  input  logic          take_en,
  input  logic [PW-1:0] take_n,
  output logic [CW-1:0] backlog
);

  logic          at_cap;
  logic          accept;
  logic [CW-1:0] after_take;

  assign at_cap     = (backlog == CW'(QDEPTH));
  assign accept     = cell_in && !at_cap;
  assign after_take = take_en ? (backlog - CW'(take_n)) : backlog;

  always_ff @(posedge clk) begin
    if (!rst_n) backlog <= '0;
    else        backlog <= after_take + CW'(accept);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= CW'(QDEPTH)); // R9

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_cap && !take_en) |=> backlog == CW'(QDEPTH)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_en && !cell_in) |=> $stable(backlog)); // R5

endmodule

// File: rtl/env_age_timer.sv
module env_age_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  localparam logic [TW-1:0] AGE_MAX = '1;

  logic [TW-1:0] age;
  logic          can_tick;

  assign can_tick = active && (age != AGE_MAX);
  assign expired  = (limit != '0) && (age >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        age <= '0;
    else if (clear)    age <= '0;
    else if (can_tick) age <= age + 1'b1;
  end

  AST_AGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (age == '0)); // R8

  AST_AGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable(age)); // R3

  AST_TMO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !expired); // R4

endmodule

// File: rtl/env_report.sv
module env_report #(
  parameter int ENV_CELLS = 4,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [PW-1:0] taken,
  output logic          rpt_vld,
  output logic [PW-1:0] rpt_cells,
  output logic [PW-1:0] rpt_pad,
  output logic          rpt_padded
);

  import env_asm_pkg::*;

  logic [PW-1:0] pad_n;
  assign pad_n = PW'(pad_of(int'(taken), ENV_CELLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_vld    <= 1'b0;
      rpt_cells  <= '0;
      rpt_pad    <= '0;
      rpt_padded <= 1'b0;
    end else begin
      rpt_vld <= fire;
      if (fire) begin
        rpt_cells  <= taken;
        rpt_pad    <= pad_n;
        rpt_padded <= (pad_n != '0);
      end
    end
  end

  AST_RPT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld |-> (int'(rpt_cells) + int'(rpt_pad) == ENV_CELLS)); // R6

  AST_RPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld |-> $past(fire)); // R6

  AST_RPT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld |-> (rpt_cells != '0)); // R6

endmodule

// File: rtl/env_assembler.sv
module env_assembler #(
  parameter int ENV_CELLS = 4,
  parameter int QDEPTH    = 15,
  parameter int TMO_W     = 8,
  localparam int CW       = $clog2(QDEPTH + 1),
  localparam int PW       = $clog2(ENV_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_in,
  input  logic             grant_in,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             env_req,
  output logic             rpt_vld,
  output logic [PW-1:0]    rpt_cells,
  output logic [PW-1:0]    rpt_pad,
  output logic             rpt_padded
);

  import env_asm_pkg::*;

  logic [CW-1:0] backlog;
  logic [PW-1:0] take_n;
  logic          env_full;
  logic          env_aged;
  logic          tmo_fire;
  logic          grant_take;
  logic          q_busy;

  assign q_busy     = (backlog != '0);
  assign env_full   = (int'(backlog) >= ENV_CELLS);
  assign env_aged   = tmo_fire && q_busy;
  assign env_req    = env_full || env_aged;
  assign grant_take = grant_in && env_req;
  assign take_n     = PW'(take_of(int'(backlog), ENV_CELLS));

  env_backlog_ctr #(.QDEPTH(QDEPTH), .CW(CW), .PW(PW)) i_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cell_in (cell_in),
    .take_en (grant_take),
    .take_n  (take_n),
    .backlog (backlog)
  );

  env_age_timer #(.TW(TMO_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (q_busy),
    .clear   (grant_take),
    .limit   (tmo_limit),
    .expired (tmo_fire)
  );

  env_report #(.ENV_CELLS(ENV_CELLS), .PW(PW)) i_rpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (grant_take),
    .taken      (take_n),
    .rpt_vld    (rpt_vld),
    .rpt_cells  (rpt_cells),
    .rpt_pad    (rpt_pad),
    .rpt_padded (rpt_padded)
  );

  AST_FULL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(backlog) >= ENV_CELLS) |-> env_req); // R2

  AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !q_busy |-> !env_req); // R3

  AST_DISABLED_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmo_limit == '0) && (int'(backlog) < ENV_CELLS)) |-> !env_req); // R4

  AST_GRANT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_in && !env_req) |=> !rpt_vld); // R5

  AST_GRANT_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_take && cell_in && (backlog != CW'(QDEPTH))) |=>
      (int'(backlog) == int'($past(backlog)) - int'($past(take_n)) + 1)); // R7

endmodule

// File: tb/test_env_assembler.sv
module test_env_assembler;

  localparam int K   = 4;
  localparam int QD  = 15;
  localparam int TW  = 8;
  localparam int PW  = $clog2(K + 1);
  localparam int AMX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cell_in = 1'b0;
  logic          grant_in = 1'b0;
  logic [TW-1:0] tmo_limit = '0;
  logic          env_req;
  logic          rpt_vld;
  logic [PW-1:0] rpt_cells;
  logic [PW-1:0] rpt_pad;
  logic          rpt_padded;

  int checks = 0;
  int errors = 0;
  int mb = 0;   // expected backlog
  int ma = 0;   // expected age
  int mt = 0;   // timer limit in use
  bit done = 0;

  always #5 clk = ~clk;

  env_assembler #(.ENV_CELLS(K), .QDEPTH(QD), .TMO_W(TW)) i_env_assembler (
    .clk(clk), .rst_n(rst_n), .cell_in(cell_in), .grant_in(grant_in),
    .tmo_limit(tmo_limit), .env_req(env_req), .rpt_vld(rpt_vld),
    .rpt_cells(rpt_cells), .rpt_pad(rpt_pad), .rpt_padded(rpt_padded)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit want_req();
    return (mb >= K) || (mt != 0 && ma >= mt && mb != 0);
  endfunction

  task automatic do_reset(input int t);
    mt = t;
    tmo_limit = TW'(t);
    rst_n = 1'b0;
    cell_in = 1'b0;
    grant_in = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mb = 0; ma = 0;
    chk(env_req == 1'b0, "R1", "env_req after reset", int'(env_req), 0);
    chk(rpt_vld == 1'b0, "R1", "rpt_vld after reset", int'(rpt_vld), 0);
  endtask

  // one clock with the given inputs; expected state follows the requirements
  task automatic step(input bit c, input bit g, input string tag);
    bit rq;
    bit rv;
    int sent;
    cell_in = c;
    grant_in = g;
    rq = want_req();
    rv = g && rq;
    sent = 0;
    if (rv) sent = (mb < K) ? mb : K;
    if (rv) ma = 0;
    else if (mb != 0 && ma < AMX) ma = ma + 1;
    mb = mb - sent + ((c && mb != QD) ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
    cell_in = 1'b0;
    grant_in = 1'b0;
    chk(env_req == want_req(), tag, "env_req", int'(env_req), int'(want_req()));
    chk(rpt_vld == rv, tag, "rpt_vld", int'(rpt_vld), int'(rv));
    if (rv) begin
      chk(int'(rpt_cells) == sent, "R6", "rpt_cells", int'(rpt_cells), sent);
      chk(int'(rpt_pad) == K - sent, "R6", "rpt_pad", int'(rpt_pad), K - sent);
      chk(rpt_padded == (sent != K), "R6", "rpt_padded",
          int'(rpt_padded), int'(sent != K));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(0);

    // R2 / R3: every partial fill against several timer limits
    for (int t = 1; t <= 5; t++) begin
      for (int n = 1; n <= K; n++) begin
        do_reset(t);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, (n == K) ? "R2" : "R3");
        for (int i = 0; i < t + 2; i++) step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, "R6");
      end
    end

    // R4: timer disabled, wait past age saturation
    do_reset(0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R4");
    for (int i = 0; i < AMX + 20; i++) step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, "R6");

    // R5: grant with no request changes nothing
    do_reset(0);
    step(1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, "R5");

    // R7: cell with grant goes to the next envelope
    do_reset(0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, "R7");
    do_reset(0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");

    // R8: leftover cells age from the grant edge
    do_reset(3);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, "R8");

    // R9: backlog saturates at the queue depth
    do_reset(0);
    for (int i = 0; i < QD + 5; i++) step(1'b1, 1'b0, "R9");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, "R9");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule